// File: doc/BRIEF.md
# UART Receiver with Clear-on-Read Error Status

This block receives asynchronous serial frames on a single input line and turns each one into a byte. Each bit is sampled once, at the middle of a bit period that is divided into 16 oversampling ticks. The byte is placed in a one-byte receive buffer. Three sticky error flags sit in an 8-bit status register: parity mismatch, missing stop bit and overrun. Both the buffer and the status register are read through a small read port whose data follows the address combinationally. An access is committed at the clock edge on which the read strobe is high.

Reading the status register clears its flags. Reading the buffer empties it. If a frame completes while the buffer still holds an unread byte, the new byte is dropped and the overrun flag is raised. The receiver runs only while both the unit enable and the receive enable are high. Dropping either one puts the receiver back in idle and clears all flags. A one-cycle completion pulse marks every finished frame, including frames that overran.

Top module: `uart_rx_stat`

## Requirements
- R1: After reset the status register reads 0x00 and the buffer reads 0x00. Status bits 7 to 3 always read 0. The address encoding is 0 = receive buffer and 1 = status.
- R2: A frame is one low start bit, eight data bits sent least significant bit first, an optional parity bit, and one or two stop bits. Each bit lasts 16 ticks of CLKS_PER_TICK clocks. A valid frame loads its data byte into the buffer.
- R3: Parity mode 00 and 01 carry no parity bit and never set status bit 2. Mode 10 is odd parity and mode 11 is even parity. In those modes, status bit 2 is set when the data bits and the parity bit together have the wrong number of ones.
- R4: Status bit 1 is set when the first stop bit is sampled low. When two stop bits are selected, the second is not checked.
- R5: When a frame completes while the buffer is full, status bit 0 is set. The new byte is discarded and the buffer keeps the old byte.
- R6: A status read returns the current flags and clears all three of them at that clock edge.
- R7: While the unit enable or the receive enable is low, all three flags are held at 0.
- R8: A start bit that is high again at its middle sample is ignored. No completion is reported and the buffer is not touched.
- R9: If a flag is set in the same cycle as a status read, the flag ends up set.
- R10: rx_done_o pulses high for exactly one cycle for each completed frame.
- R11: A buffer read empties the buffer, so the next frame is stored without an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial receive line, idle high |
| unit_en_i | input | 1 | Unit enable |
| rx_en_i | input | 1 | Receive enable |
| parity_mode_i | input | 2 | 00/01 no parity, 10 odd, 11 even |
| two_stop_i | input | 1 | 1 = two stop bits per frame |
| rd_en_i | input | 1 | Read strobe; the access is committed at the clock edge |
| rd_addr_i | input | 1 | 0 = receive buffer, 1 = status |
| rd_data_o | output | 8 | Read data for the current address |
| rx_done_o | output | 1 | One-cycle frame completion pulse |

## Verification
The assertions assume that the parity mode and the stop-bit selection stay constant while a frame is in flight. They also assume that the serial line is held steady for whole bit periods of exactly 16 ticks. The stimulus changes the mode settings only between frames, with the line idle. It drives every bit for a fixed whole number of clocks that matches the receiver's bit period. The only shorter pulse on the line is the deliberate start glitch, which lasts a quarter of a bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_RSVD = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_mode_e;

  localparam logic ADDR_BUF  = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  typedef struct packed {
    logic pe;
    logic fe;
    logic ovr;
  } err_flags_t;

  function automatic logic frame_has_parity(input logic [1:0] mode);
    return mode[1];
  endfunction

  function automatic logic parity_bad(input logic [BYTE_W-1:0] d,
                                      input logic p,
                                      input logic [1:0] mode);
    logic ones_odd;
    ones_odd = (^d) ^ p;
    case (mode)
      PAR_ODD:  return ~ones_odd;
      PAR_EVEN: return ones_odd;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
  parameter int CLKS_PER_TICK = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_TICK - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                       cnt_q <= '0;
    else if (restart_i || cnt_q == LAST) cnt_q <= '0;
    else                               cnt_q <= cnt_q + 1'b1;

  assign tick_o = !restart_i && (cnt_q == LAST);
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              rxd_i,
  input  logic              tick_i,
  input  logic [1:0]        parity_mode_i,
  input  logic              two_stop_i,
  output logic              start_seen_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              pe_o,
  output logic              fe_o
);
  localparam int TW = $clog2(OVERSAMPLE);
  localparam logic [TW-1:0] T_LAST = TW'(OVERSAMPLE - 1);
  localparam logic [TW-1:0] T_HALF = TW'(OVERSAMPLE / 2 - 1);
  localparam int BW = $clog2(BYTE_W);
  localparam logic [BW-1:0] B_LAST = BW'(BYTE_W - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2} state_e;

  state_e            state_q;
  logic [TW-1:0]     tcnt_q;
  logic [BW-1:0]     bcnt_q;
  logic [BYTE_W-1:0] shift_q;
  logic              pbit_q;
  logic              prev_q;
  logic              bit_mid;
  logic              half_mid;

  assign start_seen_o = active_i && (state_q == S_IDLE) && prev_q && !rxd_i;
  assign bit_mid      = tick_i && (tcnt_q == T_LAST);
  assign half_mid     = tick_i && (tcnt_q == T_HALF);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= rxd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      shift_q <= '0;
      pbit_q  <= 1'b0;
      done_o  <= 1'b0;
      data_o  <= '0;
      pe_o    <= 1'b0;
      fe_o    <= 1'b0;
    end else if (!active_i) begin
      state_q <= S_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i && !bit_mid && !(state_q == S_START && half_mid))
        tcnt_q <= tcnt_q + 1'b1;
      case (state_q)
        S_IDLE: begin
          if (start_seen_o) begin
            state_q <= S_START;
            tcnt_q  <= '0;
          end
        end
        S_START: begin
          if (half_mid) begin
            tcnt_q  <= '0;
            bcnt_q  <= '0;
            state_q <= rxd_i ? S_IDLE : S_DATA;
          end
        end
        S_DATA: begin
          if (bit_mid) begin
            tcnt_q  <= '0;
            shift_q <= {rxd_i, shift_q[BYTE_W-1:1]};
            bcnt_q  <= bcnt_q + 1'b1;
            if (bcnt_q == B_LAST)
              state_q <= frame_has_parity(parity_mode_i) ? S_PAR : S_STOP1;
          end
        end
        S_PAR: begin
          if (bit_mid) begin
            tcnt_q  <= '0;
            pbit_q  <= rxd_i;
            state_q <= S_STOP1;
          end
        end
        S_STOP1: begin
          if (bit_mid) begin
            tcnt_q  <= '0;
            done_o  <= 1'b1;
            data_o  <= shift_q;
            fe_o    <= !rxd_i;
            pe_o    <= frame_has_parity(parity_mode_i) &&
                       parity_bad(shift_q, pbit_q, parity_mode_i);
            state_q <= two_stop_i ? S_STOP2 : S_IDLE;
          end
        end
        S_STOP2: begin
          if (bit_mid) begin
            tcnt_q  <= '0;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
  import uart_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              done_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              pe_i,
  input  logic              fe_i,
  input  logic              rd_buf_i,
  input  logic              rd_stat_i,
  output logic [BYTE_W-1:0] buf_o,
  output err_flags_t        flags_o
);
  logic full_q;
  logic ovr_evt;
  logic store;

  assign ovr_evt = done_i && full_q && !rd_buf_i;
  assign store   = done_i && !ovr_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_o  <= '0;
      full_q <= 1'b0;
    end else if (store) begin
      buf_o  <= data_i;
      full_q <= 1'b1;
    end else if (rd_buf_i) begin
      full_q <= 1'b0;
    end
  end

  function automatic logic flag_next(input logic cur, input logic set,
                                     input logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
    end else begin
      flags_o.pe  <= flag_next(flags_o.pe,  done_i && pe_i, rd_stat_i || !active_i);
      flags_o.fe  <= flag_next(flags_o.fe,  done_i && fe_i, rd_stat_i || !active_i);
      flags_o.ovr <= flag_next(flags_o.ovr, ovr_evt,        rd_stat_i || !active_i);
    end
  end
endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat
  import uart_rx_pkg::*;
#(
  parameter int CLKS_PER_TICK = 4,
  parameter int OVERSAMPLE    = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rxd_i,
  input  logic       unit_en_i,
  input  logic       rx_en_i,
  input  logic [1:0] parity_mode_i,
  input  logic       two_stop_i,
  input  logic       rd_en_i,
  input  logic       rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic       rx_done_o
);
  logic              rx_active;
  logic              rxd_s;
  logic              tick;
  logic              start_seen;
  logic              frame_done;
  logic [BYTE_W-1:0] frame_data;
  logic              frame_pe;
  logic              frame_fe;
  logic              rd_buf;
  logic              rd_stat;
  logic [BYTE_W-1:0] buf_q;
  err_flags_t        flags_q;

  assign rx_active = unit_en_i && rx_en_i;
  assign rd_buf    = rd_en_i && (rd_addr_i == ADDR_BUF);
  assign rd_stat   = rd_en_i && (rd_addr_i == ADDR_STAT);

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(rxd_s)
  );

  uart_rx_tick #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(start_seen), .tick_o(tick)
  );

  uart_rx_frame #(.OVERSAMPLE(OVERSAMPLE)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(rx_active), .rxd_i(rxd_s),
    .tick_i(tick), .parity_mode_i(parity_mode_i), .two_stop_i(two_stop_i),
    .start_seen_o(start_seen), .done_o(frame_done), .data_o(frame_data),
    .pe_o(frame_pe), .fe_o(frame_fe)
  );

  uart_rx_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(rx_active), .done_i(frame_done),
    .data_i(frame_data), .pe_i(frame_pe), .fe_i(frame_fe),
    .rd_buf_i(rd_buf), .rd_stat_i(rd_stat), .buf_o(buf_q), .flags_o(flags_q)
  );

  assign rd_data_o = (rd_addr_i == ADDR_STAT) ? {5'b0, flags_q} : buf_q;
  assign rx_done_o = frame_done;
endmodule

// File: rtl/uart_rx_stat_chk.sv
module uart_rx_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       active,
  input logic       rd_en,
  input logic       rd_addr,
  input logic [7:0] rd_data,
  input logic       done,
  input logic       fe_evt,
  input logic [7:0] buf_q,
  input logic [2:0] stat
);
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr |-> rd_data[7:3] == 5'b0);

  a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> stat == 3'b000);

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr && !done) |=> stat == 3'b000);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fe_evt && active) |=> stat[1]);

  a_r5_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[0]) |-> $stable(buf_q));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind uart_rx_stat uart_rx_stat_chk u_chk (
  .clk(clk_i), .rst_n(rst_ni), .active(rx_active), .rd_en(rd_en_i),
  .rd_addr(rd_addr_i), .rd_data(rd_data_o), .done(frame_done),
  .fe_evt(frame_fe), .buf_q(buf_q), .stat(flags_q)
);

// File: tb/uart_rx_stat_test.sv
module uart_rx_stat_test;
  localparam int CPT = 4;
  localparam int BIT = 16 * CPT;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       unit_en = 1'b1;
  logic       rx_en = 1'b1;
  logic [1:0] pmode = 2'b00;
  logic       two_stop = 1'b0;
  logic       rd_en = 1'b0;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic       rx_done;

  int errors = 0;
  int checks = 0;
  int ndone = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  uart_rx_stat #(.CLKS_PER_TICK(CPT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .unit_en_i(unit_en),
    .rx_en_i(rx_en), .parity_mode_i(pmode), .two_stop_i(two_stop),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rx_done_o(rx_done)
  );

  always @(posedge clk) if (rx_done) ndone++;

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic read_reg(input logic a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic hold_bit(input logic b);
    rxd = b;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit par, input logic pbit,
                            input logic s1, input logic s2);
    @(negedge clk);
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) hold_bit(d[i]);
    if (par) hold_bit(pbit);
    hold_bit(s1);
    if (two_stop) hold_bit(s2);
    rxd = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic drain;
    logic [7:0] v;
    read_reg(1'b0, v);
    read_reg(1'b1, v);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    read_reg(1'b1, v); check("R1 reset status", v, 8'h00);
    read_reg(1'b0, v); check("R1 reset buffer", v, 8'h00);
  endtask

  task automatic t_basic;
    logic [7:0] v;
    int n0;
    n0 = ndone;
    pmode = 2'b00;
    send_frame(8'hA5, 0, 0, 1, 1);
    check("R10 one done pulse per frame", ndone - n0, 1);
    read_reg(1'b1, v); check("R2 clean frame status", v, 8'h00);
    read_reg(1'b0, v); check("R2 data lsb first", v, 8'hA5);
    send_frame(8'h01, 0, 0, 1, 1);
    read_reg(1'b0, v); check("R2 second byte", v, 8'h01);
  endtask

  task automatic t_parity;
    logic [7:0] v;
    pmode = 2'b10;
    send_frame(8'h3C, 1, ~^8'h3C, 1, 1);
    read_reg(1'b1, v); check("R3 odd parity good", v, 8'h00);
    read_reg(1'b0, v); check("R3 odd data", v, 8'h3C);
    send_frame(8'h3C, 1, ^8'h3C, 1, 1);
    read_reg(1'b1, v); check("R3 odd parity bad", v, 8'h04);
    drain();
    pmode = 2'b11;
    send_frame(8'h07, 1, ~^8'h07, 1, 1);
    read_reg(1'b1, v); check("R3 even parity bad", v, 8'h04);
    drain();
    send_frame(8'h07, 1, ^8'h07, 1, 1);
    read_reg(1'b1, v); check("R3 even parity good", v, 8'h00);
    drain();
    pmode = 2'b01;
    send_frame(8'h5A, 0, 0, 1, 1);
    read_reg(1'b1, v); check("R3 reserved mode no check", v, 8'h00);
    read_reg(1'b0, v); check("R3 reserved mode data", v, 8'h5A);
    pmode = 2'b00;
  endtask

  task automatic t_framing;
    logic [7:0] v;
    send_frame(8'h81, 0, 0, 0, 1);
    read_reg(1'b1, v); check("R4 low first stop", v, 8'h02);
    drain();
    two_stop = 1'b1;
    send_frame(8'h42, 0, 0, 1, 0);
    read_reg(1'b1, v); check("R4 second stop unchecked", v, 8'h00);
    read_reg(1'b0, v); check("R4 two-stop data", v, 8'h42);
    two_stop = 1'b0;
  endtask

  task automatic t_overrun;
    logic [7:0] v;
    send_frame(8'h11, 0, 0, 1, 1);
    send_frame(8'h22, 0, 0, 1, 1);
    read_reg(1'b1, v); check("R5 overrun flag", v, 8'h01);
    read_reg(1'b0, v); check("R5 old byte kept", v, 8'h11);
    send_frame(8'h33, 0, 0, 1, 1);
    read_reg(1'b1, v); check("R11 no overrun after read", v, 8'h00);
    read_reg(1'b0, v); check("R11 new byte stored", v, 8'h33);
  endtask

  task automatic t_read_clear;
    logic [7:0] v;
    send_frame(8'h00, 0, 0, 0, 1);
    read_reg(1'b1, v); check("R6 read returns flags", v, 8'h02);
    read_reg(1'b1, v); check("R6 flags cleared by read", v, 8'h00);
    drain();
  endtask

  task automatic t_disable;
    logic [7:0] v;
    send_frame(8'hF0, 0, 0, 0, 1);
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk); rx_en = 1'b1;
    read_reg(1'b1, v); check("R7 rx disable clears", v, 8'h00);
    drain();
    send_frame(8'hF0, 0, 0, 0, 1);
    @(negedge clk); unit_en = 1'b0;
    @(negedge clk); unit_en = 1'b1;
    read_reg(1'b1, v); check("R7 unit disable clears", v, 8'h00);
    drain();
  endtask

  task automatic t_glitch;
    logic [7:0] v;
    int n0;
    n0 = ndone;
    @(negedge clk); rxd = 1'b0;
    repeat (BIT / 4) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * BIT) @(negedge clk);
    check("R8 glitch gives no done", ndone - n0, 0);
    read_reg(1'b0, v); check("R8 buffer untouched", v, 8'hF0);
    read_reg(1'b1, v); check("R8 status untouched", v, 8'h00);
  endtask

  task automatic t_set_wins;
    logic [7:0] v;
    fork
      send_frame(8'h99, 0, 0, 0, 1);
      begin
        @(negedge clk);
        while (!rx_done) @(negedge clk);
        rd_en = 1'b1; rd_addr = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
      end
    join
    read_reg(1'b1, v); check("R9 set beats clear", v, 8'h02);
    drain();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_basic();
    t_parity();
    t_framing();
    t_overrun();
    t_read_clear();
    t_disable();
    t_glitch();
    t_set_wins();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule